// File: doc/BRIEF.md
# Complex Squared Norm Lane Unit

This block is a SIMD vector datapath built from 16-bit lanes. Each adjacent pair of lanes holds one complex Q1.15 sample. The even lane carries the real part and the odd lane carries the imaginary part. For every pair, the unit squares both parts with a lane multiplier, then rounds each product back to Q1.15 and saturates it. Next it moves each squared term across to the other lane of the pair and adds the two terms with saturation. A single clock cycle does all of this, where a multiply, a permute and an add would otherwise run as three separate steps.

The norm is written into both lanes of its pair, so a following vector operation can use either lane. The input vector comes with a valid strobe. The result appears one registered cycle later with its own valid strobe. The number of complex pairs is a parameter, so the vector can be made as wide as needed, for example 1024 bits with 32 pairs. A second parameter picks the product scaling: round to nearest (the default) or plain truncation.

Top module: `cnorm_lanes`

## Requirements
- R1: With the default rounding, each squared part is min(32767, floor((x*x + 16384) / 32768)), where x is the signed 16-bit lane value. For example 0x0080 squares to 1, 0x007F squares to 0 and 0x4000 squares to 8192.
- R2: Squaring the most negative lane value 0x8000 (-32768) gives +32767 and does not wrap.
- R3: Pair k takes its real part from in_vec bits [32k+15:32k] and its imaginary part from bits [32k+31:32k+16]. Its norm is written to both of the matching 16-bit fields of out_vec.
- R4: The norm of a pair is min(32767, sq(re) + sq(im)). For example a pair with both parts 0x7FFF gives 32767.
- R5: out_valid equals in_valid delayed by exactly one clock. Data presented with in_valid high at one rising edge is visible on out_vec after that same edge.
- R6: When in_valid is low at a rising edge, out_vec keeps its previous value, whatever in_vec holds.
- R7: While rst_n is low, out_valid is 0 and out_vec is all zeros, even if in_valid is high.
- R8: Every 16-bit field of out_vec has its sign bit (bit 15) clear.
- R9: Each pair's norm depends only on its own two lanes. Non-zero lanes in one pair leave an all-zero pair at norm 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input vector strobe |
| in_vec | input | 32*NUM_PAIRS | Complex samples, real in even lanes, imaginary in odd lanes |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_vec | output | 32*NUM_PAIRS | Norms, each duplicated into both lanes of its pair |

## Verification
The assertions check on every cycle the properties that need no arithmetic model. These are the one-cycle valid follow, the hold of the result while idle, the copy of each norm into both lanes of its pair, the clear sign bit of every field, and a zero norm for an all-zero input. The numeric result can only be shown by the bench's scenarios, because it needs an integer model. That covers the rounding point at 0x0080 against 0x007F, the saturation of the -32768 square, the saturated pair sum at full scale, and the isolation between pairs. The bench compares table vectors and random vectors against that model.

// File: rtl/cnorm_pkg.sv
package cnorm_pkg;
   localparam int unsigned LANE_W  = 16;
   localparam int unsigned PAIR_W  = 2 * LANE_W;
   localparam int unsigned PROD_W  = 2 * LANE_W;
   localparam int unsigned FRAC_W  = LANE_W - 1;
   localparam int unsigned SCALE_W = PROD_W - FRAC_W;
   localparam logic [LANE_W-1:0] LANE_MAX = {1'b0, {(LANE_W-1){1'b1}}};
   typedef logic signed [LANE_W-1:0] lane_s_t;
   typedef logic [LANE_W-1:0]        lane_u_t;
endpackage

// File: rtl/cnorm_sq_lane.sv
module cnorm_sq_lane
   import cnorm_pkg::*;
#(
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  lane_s_t x,
   output lane_u_t sq
);
   logic signed [PROD_W-1:0] prod;
   logic [PROD_W-1:0]        prod_u;
   logic [PROD_W-1:0]        biased;
   logic [SCALE_W-1:0]       scaled;

   always_comb begin
      prod   = PROD_W'(x) * PROD_W'(x);
      prod_u = prod;
   end

   generate
      if (ROUND_NEAREST) begin : g_round
         assign biased = prod_u + PROD_W'(1 << (FRAC_W - 1));
      end else begin : g_trunc
         assign biased = prod_u;
      end
   endgenerate

   assign scaled = biased[PROD_W-1:FRAC_W];

   always_comb begin
      if (|scaled[SCALE_W-1:LANE_W-1]) sq = LANE_MAX;
      else                             sq = scaled[LANE_W-1:0];
   end
endmodule

// File: rtl/cnorm_pair.sv
module cnorm_pair
   import cnorm_pkg::*;
#(
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  lane_s_t re,
   input  lane_s_t im,
   output lane_u_t norm
);
   lane_u_t           sq_re;
   lane_u_t           sq_im;
   logic [LANE_W:0]   sum;

   cnorm_sq_lane #(.ROUND_NEAREST(ROUND_NEAREST)) u_sq_re (.x(re), .sq(sq_re));
   cnorm_sq_lane #(.ROUND_NEAREST(ROUND_NEAREST)) u_sq_im (.x(im), .sq(sq_im));

   // each squared term is non-negative, so only the positive limit can be crossed
   assign sum = {1'b0, sq_re} + {1'b0, sq_im};

   always_comb begin
      if (sum[LANE_W] | sum[LANE_W-1]) norm = LANE_MAX;
      else                             norm = sum[LANE_W-1:0];
   end
endmodule

// File: rtl/cnorm_lanes.sv
module cnorm_lanes
   import cnorm_pkg::*;
#(
   parameter int unsigned NUM_PAIRS     = 4,
   parameter bit          ROUND_NEAREST = 1'b1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                in_valid,
   input  logic [NUM_PAIRS*2*LANE_W-1:0]       in_vec,
   output logic                                out_valid,
   output logic [NUM_PAIRS*2*LANE_W-1:0]       out_vec
);
   localparam int unsigned VEC_W = NUM_PAIRS * PAIR_W;

   generate
      if (NUM_PAIRS < 1) begin : g_bad_pairs
         $error("cnorm_lanes: NUM_PAIRS must be at least 1");
      end
   endgenerate

   logic [VEC_W-1:0] next_vec;

   generate
      for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
         lane_u_t norm;
         cnorm_pair #(.ROUND_NEAREST(ROUND_NEAREST)) u_pair (
            .re   (in_vec[p*PAIR_W +: LANE_W]),
            .im   (in_vec[p*PAIR_W + LANE_W +: LANE_W]),
            .norm (norm)
         );
         assign next_vec[p*PAIR_W +: LANE_W]          = norm;
         assign next_vec[p*PAIR_W + LANE_W +: LANE_W] = norm;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_vec   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_vec <= next_vec;
      end
   end
endmodule

// File: rtl/cnorm_lanes_chk.sv
module cnorm_lanes_chk
   import cnorm_pkg::*;
#(
   parameter int unsigned NUM_PAIRS = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          in_valid,
   input logic [NUM_PAIRS*PAIR_W-1:0]   in_vec,
   input logic                          out_valid,
   input logic [NUM_PAIRS*PAIR_W-1:0]   out_vec
);
   logic pairs_match;
   logic signs_clear;

   always_comb begin
      pairs_match = 1'b1;
      signs_clear = 1'b1;
      for (int p = 0; p < int'(NUM_PAIRS); p++) begin
         if (out_vec[p*PAIR_W +: LANE_W] != out_vec[p*PAIR_W + LANE_W +: LANE_W])
            pairs_match = 1'b0;
         if (out_vec[p*PAIR_W + LANE_W - 1] | out_vec[p*PAIR_W + PAIR_W - 1])
            signs_clear = 1'b0;
      end
   end

   AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R5
   AST_VALID_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R5
   AST_HOLD_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_vec)); // R6
   AST_PAIR_COPY:    assert property (@(posedge clk) disable iff (!rst_n) pairs_match); // R3
   AST_NON_NEG:      assert property (@(posedge clk) disable iff (!rst_n) signs_clear); // R8
   AST_ZERO_NORM:    assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_vec == '0) |=> (out_vec == '0)); // R1
endmodule

bind cnorm_lanes cnorm_lanes_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
   .out_valid(out_valid), .out_vec(out_vec)
);

// File: tb/cnorm_lanes_test.sv
module cnorm_lanes_test;
   localparam int NP = 4;
   localparam int VW = NP * 32;
   localparam int NTBL = 6;
   localparam longint WDOG_NS = 200000 * 4;

   // each entry, MSB first: pair3 {im,re}, pair2, pair1, pair0
   localparam logic [VW-1:0] TBL [0:NTBL-1] = '{
      {16'h0000,16'h0000, 16'h0000,16'h0000, 16'h0000,16'h0000, 16'h0000,16'h0000},
      {16'h0000,16'h7FFF, 16'h7FFF,16'h0000, 16'h7FFF,16'h7FFF, 16'h8000,16'h0000},
      {16'h0080,16'h0000, 16'h007F,16'h0000, 16'h4000,16'h4000, 16'hC000,16'h0000},
      {16'h8000,16'h8000, 16'h0001,16'hFFFF, 16'h2000,16'h6000, 16'hFF80,16'h0080},
      {16'h0000,16'h0000, 16'h1234,16'h8001, 16'h0000,16'h0000, 16'h0000,16'h0000},
      {16'h1A2B,16'hE5D4, 16'h0F0F,16'hF0F1, 16'h3000,16'hD000, 16'h5A5A,16'hA5A6}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [VW-1:0] in_vec = '0;
   logic          out_valid;
   logic [VW-1:0] out_vec;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   cnorm_lanes #(.NUM_PAIRS(NP)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
      .out_valid(out_valid), .out_vec(out_vec)
   );

   function automatic longint sq_model(input logic [15:0] v);
      longint x = longint'($signed(v));
      longint r = (x * x + 16384) / 32768;
      return (r > 32767) ? 32767 : r;
   endfunction

   function automatic logic [VW-1:0] norm_model(input logic [VW-1:0] v);
      logic [VW-1:0] r;
      for (int p = 0; p < NP; p++) begin
         longint s = sq_model(v[p*32 +: 16]) + sq_model(v[p*32+16 +: 16]);
         if (s > 32767) s = 32767;
         r[p*32 +: 16]    = 16'(s);
         r[p*32+16 +: 16] = 16'(s);
      end
      return r;
   endfunction

   task automatic check_vec(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp_v);
      n_checks++;
      if (act !== exp_v) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
      end
   endtask

   task automatic check_bit(input string tag, input logic act, input logic exp_b);
      n_checks++;
      if (act !== exp_b) begin
         n_fails++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp_b);
      end
   endtask

   task automatic push(input logic [VW-1:0] v, input string tag);
      @(negedge clk);
      in_valid = 1'b1;
      in_vec   = v;
      @(posedge clk);
      #1;
      check_bit({tag, " valid"}, out_valid, 1'b1);
      check_vec(tag, out_vec, norm_model(v));
   endtask

   initial begin
      logic [VW-1:0] last;
      // R7: reset holds outputs at zero even with valid input
      in_valid = 1'b1;
      in_vec   = {NP{32'h7FFF_8000}};
      repeat (3) @(posedge clk);
      #1;
      check_bit("R7 reset valid", out_valid, 1'b0);
      check_vec("R7 reset data", out_vec, '0);
      @(negedge clk);
      in_valid = 1'b0;
      rst_n    = 1'b1;

      // table walk: R1 rounding, R2 min value, R3 layout, R4 saturated sum, R9 isolation
      for (int i = 0; i < NTBL; i++) push(TBL[i], "R1/R3/R4 table");

      // directed corners
      push(TBL[2], "R1 rounding");
      n_checks++;
      if (out_vec[111:96] !== 16'd1 || out_vec[79:64] !== 16'd0) begin
         n_fails++;
         $display("FAIL R1: actual %0d/%0d expected 1/0", out_vec[111:96], out_vec[79:64]);
      end
      push(TBL[1], "R2 min value");
      check_vec("R2 pair0 lanes", {96'h0, out_vec[31:0]}, {96'h0, 16'd32767, 16'd32767});
      check_vec("R4 full scale pair", {96'h0, out_vec[63:32]}, {96'h0, 16'd32767, 16'd32767});
      check_bit("R8 sign bits", |(out_vec & {(2*NP){16'h8000}}), 1'b0);
      push(TBL[4], "R9 isolation");
      check_vec("R9 zero pairs", out_vec & {32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0}, '0);
      check_vec("R3 lane 2k copy", {112'h0, out_vec[79:64]}, {112'h0, out_vec[95:80]});

      // R6: idle cycle keeps result
      last = out_vec;
      @(negedge clk);
      in_valid = 1'b0;
      in_vec   = {NP{32'h1234_5678}};
      @(posedge clk);
      #1;
      check_bit("R5 idle valid", out_valid, 1'b0);
      check_vec("R6 hold", out_vec, last);

      // R5: back-to-back vectors each appear one cycle later
      push(TBL[5], "R5 back-to-back a");
      push(TBL[3], "R5 back-to-back b");

      // random vectors
      for (int i = 0; i < 40; i++) begin
         logic [VW-1:0] v;
         for (int w = 0; w < VW / 32; w++) v[w*32 +: 32] = $urandom();
         push(v, "R4 random");
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

   initial begin
      #(WDOG_NS);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   end
endmodule